// File: doc/BRIEF.md
# Byte-wide SPI master with register port

This block is an SPI master that moves exactly one 8-bit word per request. Software configures it through a small synchronous register port: a configuration byte (clock polarity, sampling phase, bit order, port enable, internal loopback), an 8-bit clock divisor, a transmit byte and a receive byte. Writing the go bit in the command register shifts the transmit byte out on `mosi` while the byte arriving on `miso` is shifted in.

The block has no queue. Every finished byte sets a receive-ready flag and raises `irq`. The busy flag drops one clock after that, and software must read the receive byte before it starts the next transfer. The serial clock runs at the system clock divided by 4·(divisor+1). The register port has no back-pressure: a write or a read takes effect in the cycle it is presented, and read data is combinational from the address.

Top module: `spi_byte_master`

## Requirements
- R1: After reset the configuration, divisor, transmit and receive registers hold 0, the status reads 0x00, and `irq`, `sck` and `mosi` are 0.
- R2: Writing a value with bit 0 set to the command register (offset 3) starts a transfer only when the enable bit (0x08) is set in the configuration register (offset 0) and the block is idle. Otherwise the write is ignored: the status and the serial pins do not change, and a transfer in progress keeps its original length.
- R3: During a transfer `sck` makes 8 full periods, each 4·(divisor+1) clocks long (divisor at offset 5). Outside a transfer `sck` rests at the idle level given by configuration bit 0x02 (1 = high).
- R4: With configuration bit 0x10 = 1, `mosi` carries the first bit before the first `sck` edge, and `miso` is captured on the first (leading) edge of each period. With bit 0x10 = 0, `mosi` changes on leading edges and `miso` is captured on trailing edges.
- R5: With configuration bit 0x04 = 0 the byte is sent and assembled MSB first. With bit 0x04 = 1 it is sent and assembled LSB first.
- R6: With configuration bit 0x01 = 1 the received byte equals the transmitted byte, and `miso` is ignored.
- R7: At the last `sck` edge, the received byte is loaded into the receive register (offset 1). In the same clock, `irq` and status bit 0x01 (ready) rise. Status bit 0x02 (busy) stays set for exactly one more clock and then clears. From the go write, `irq` is seen after 32·(divisor+1) clocks.
- R8: Reading the receive register clears `irq` and the ready bit.
- R9: The configuration register reads back only its low five bits. The transmit register (offset 2) and the divisor read back as written. The command register reads 0.
- R10: While idle, `mosi` holds the last value it drove.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (side effect on receive register) |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| irq | output | 1 | Byte-complete interrupt, level |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench builds the block with its default 8-bit register and divisor widths. It programs divisor values from 0 to 3, which keeps each transfer between 32 and 128 clocks, so all four clock modes, both bit orders and both loopback settings can be run in one pass. A behavioural slave on the bench side checks every `sck` gap and reassembles the `mosi` byte. The small divisors also make a go write issued in the middle of a transfer easy to place.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 3;

  // register offsets
  localparam logic [ADDR_W-1:0] A_CFG  = 3'd0;
  localparam logic [ADDR_W-1:0] A_RXD  = 3'd1;
  localparam logic [ADDR_W-1:0] A_TXD  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMD  = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd4;
  localparam logic [ADDR_W-1:0] A_DIV  = 3'd5;

  localparam int CFG_USED = 5;

  // packed from bit 4 down to bit 0
  typedef struct packed {
    logic lead;   // 0x10 capture on leading edge
    logic en;     // 0x08 port enable
    logic lsb;    // 0x04 LSB first
    logic cidle;  // 0x02 clock idles high
    logic loop;   // 0x01 internal loopback
  } cfg_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_TAIL} eng_st_t;
endpackage

// File: rtl/spi_byte_clkdiv.sv
module spi_byte_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  // half period of sck is 2*(div+1) clocks
  assign limit = {div, 1'b1};
  assign tick  = run && (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (!rst_n || !run || tick) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_byte_engine.sv
module spi_byte_engine
  import spi_byte_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  cfg_t         cfg,
  input  logic [W-1:0] tx_byte,
  input  logic         miso,
  input  logic         tick,
  output logic         run,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] rx_byte,
  output logic         sck,
  output logic         mosi
);
  localparam int EDGES = 2 * W;
  localparam int EC_W  = $clog2(EDGES + 1);

  eng_st_t      st_q;
  cfg_t         cfg_q;
  logic [W-1:0] tx_sh, rx_sh, rx_nxt, tx_adv, first_rest;
  logic [EC_W-1:0] edge_q;
  logic         sck_q, mosi_q;
  logic         leading, last_edge, samp, drv, in_bit, cur_bit, first_bit;

  assign run       = (st_q == ST_RUN);
  assign busy      = (st_q != ST_IDLE);
  assign leading   = ~edge_q[0];
  assign last_edge = (edge_q == EC_W'(EDGES - 1));
  assign samp      = run && tick && (leading == cfg_q.lead);
  assign drv       = run && tick && !samp && !last_edge;
  assign done      = run && tick && last_edge;

  assign in_bit    = cfg_q.loop ? mosi_q : miso;
  assign rx_nxt    = cfg_q.lsb ? {in_bit, rx_sh[W-1:1]} : {rx_sh[W-2:0], in_bit};
  assign rx_byte   = samp ? rx_nxt : rx_sh;

  assign cur_bit    = cfg_q.lsb ? tx_sh[0] : tx_sh[W-1];
  assign tx_adv     = cfg_q.lsb ? (tx_sh >> 1) : (tx_sh << 1);
  assign first_bit  = cfg.lsb ? tx_byte[0] : tx_byte[W-1];
  assign first_rest = cfg.lsb ? (tx_byte >> 1) : (tx_byte << 1);

  assign sck  = sck_q;
  assign mosi = mosi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cfg_q  <= '0;
      tx_sh  <= '0;
      rx_sh  <= '0;
      edge_q <= '0;
      sck_q  <= 1'b0;
      mosi_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          sck_q <= cfg.cidle;
          if (start) begin
            st_q   <= ST_RUN;
            cfg_q  <= cfg;
            edge_q <= '0;
            rx_sh  <= '0;
            if (cfg.lead) begin
              mosi_q <= first_bit;
              tx_sh  <= first_rest;
            end else begin
              tx_sh  <= tx_byte;
            end
          end
        end
        ST_RUN: begin
          if (tick) begin
            sck_q  <= ~sck_q;
            edge_q <= edge_q + 1'b1;
            if (samp) rx_sh <= rx_nxt;
            if (drv) begin
              mosi_q <= cur_bit;
              tx_sh  <= tx_adv;
            end
            if (last_edge) st_q <= ST_TAIL;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spi_byte_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);
  logic [CFG_USED-1:0] cfg_q;
  logic [REG_W-1:0]    div_q, txd_q, rxd_q;
  logic                rdy_q;
  cfg_t                cfg;
  logic                wr_cmd, rd_rxd, start_go;
  logic                eng_run, eng_busy, eng_done, tick;
  logic [REG_W-1:0]    eng_rx;

  assign cfg      = cfg_t'(cfg_q);
  assign wr_cmd   = reg_we && (reg_addr == A_CMD);
  assign rd_rxd   = reg_re && (reg_addr == A_RXD);
  assign start_go = wr_cmd && reg_wdata[0] && cfg.en && !eng_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
      div_q <= '0;
      txd_q <= '0;
      rxd_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      if (reg_we && reg_addr == A_CFG) cfg_q <= reg_wdata[CFG_USED-1:0];
      if (reg_we && reg_addr == A_DIV) div_q <= reg_wdata;
      if (reg_we && reg_addr == A_TXD) txd_q <= reg_wdata;
      if (eng_done) begin
        rxd_q <= eng_rx;
        rdy_q <= 1'b1;
      end else if (rd_rxd) begin
        rdy_q <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (reg_addr)
      A_CFG:   reg_rdata = REG_W'(cfg_q);
      A_RXD:   reg_rdata = rxd_q;
      A_TXD:   reg_rdata = txd_q;
      A_STAT:  reg_rdata = {{(REG_W-2){1'b0}}, eng_busy, rdy_q};
      A_DIV:   reg_rdata = div_q;
      default: reg_rdata = '0;
    endcase
  end

  assign irq = rdy_q;

  spi_byte_clkdiv #(.DIV_W(REG_W)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (eng_run),
    .div  (div_q),
    .tick (tick)
  );

  spi_byte_engine #(.W(REG_W)) u_eng (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start_go),
    .cfg    (cfg),
    .tx_byte(txd_q),
    .miso   (miso),
    .tick   (tick),
    .run    (eng_run),
    .busy   (eng_busy),
    .done   (eng_done),
    .rx_byte(eng_rx),
    .sck    (sck),
    .mosi   (mosi)
  );
endmodule

// File: rtl/spi_byte_master_chk.sv
module spi_byte_master_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic cidle,
  input logic en,
  input logic sck,
  input logic mosi,
  input logic irq,
  input logic wr_cmd,
  input logic rd_rxd
);
  AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(en)); // R2

  AST_SCK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> (sck == $past(cidle))); // R3

  AST_DONE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (irq && busy)); // R7

  AST_BUSY_DROPS_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ##1 !busy); // R7

  AST_READ_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rxd && !done) |=> !irq); // R8

  AST_MOSI_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !wr_cmd) |=> $stable(mosi)); // R10
endmodule

bind spi_byte_master spi_byte_master_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .busy  (eng_busy),
  .done  (eng_done),
  .cidle (cfg.cidle),
  .en    (cfg.en),
  .sck   (sck),
  .mosi  (mosi),
  .irq   (irq),
  .wr_cmd(wr_cmd),
  .rd_rxd(rd_rxd)
);

// File: tb/sim_spi_byte_master.sv
module sim_spi_byte_master;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0, reg_re = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       irq, sck, mosi;
  logic       miso = 1'b0;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_byte_master u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .sck(sck), .mosi(mosi), .miso(miso)
  );

  typedef struct packed {
    logic [7:0] cfg;
    logic [7:0] div;
    logic [7:0] tx;
    logic [7:0] sl;
    logic [7:0] exp_rx;
  } vec_t;

  localparam vec_t VECS [0:6] = '{
    '{8'h18, 8'd0, 8'hA5, 8'h3C, 8'h3C},
    '{8'h08, 8'd1, 8'h5A, 8'hC3, 8'hC3},
    '{8'h1A, 8'd2, 8'h81, 8'h7E, 8'h7E},
    '{8'h0A, 8'd0, 8'h0F, 8'hF0, 8'hF0},
    '{8'h1C, 8'd1, 8'h01, 8'h80, 8'h80},
    '{8'h0F, 8'd0, 8'h96, 8'h00, 8'h96},
    '{8'h19, 8'd3, 8'h3B, 8'hFF, 8'h3B}
  };

  // behavioural slave
  bit         sl_run = 0, sl_lead = 0, sl_lsb = 0;
  logic [7:0] sl_tx = 0, sl_cap = 0;
  int         sl_kin = 0, sl_kout = 0, sl_edges = 0, sl_gap = 0, sl_gap_err = 0, exp_gap = 2;
  logic       prev_sck = 0;

  always @(negedge clk) begin
    if (sl_run) begin
      if (sl_lead && sl_kout == 0 && sl_edges == 0) begin
        miso = sl_lsb ? sl_tx[0] : sl_tx[7];
        sl_kout = 1;
      end
      sl_gap++;
      if (sck !== prev_sck) begin
        if (sl_edges > 0 && sl_gap != exp_gap) sl_gap_err++;
        sl_gap = 0;
        if (((sl_edges % 2) == 0) == sl_lead) begin
          if (sl_kin < 8) sl_cap[sl_lsb ? sl_kin : 7 - sl_kin] = mosi;
          sl_kin++;
        end else if (sl_kout < 8) begin
          miso = sl_lsb ? sl_tx[sl_kout] : sl_tx[7 - sl_kout];
          sl_kout++;
        end
        sl_edges++;
      end
    end
    prev_sck = sck;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic run_xfer(input vec_t v, input bit restart_mid, input string tag);
    logic [7:0] d;
    int cyc;
    wr(3'd0, v.cfg);
    wr(3'd5, v.div);
    wr(3'd2, v.tx);
    sl_tx = v.sl; sl_lead = v.cfg[4]; sl_lsb = v.cfg[2];
    sl_kin = 0; sl_kout = 0; sl_edges = 0; sl_gap = 0; sl_gap_err = 0; sl_cap = 0;
    exp_gap = 2 * (int'(v.div) + 1);
    sl_run = 1;
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd3; reg_wdata = 8'h01;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
    cyc = 0;
    while (!irq && cyc < 400) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      reg_we = 1'b0;
      if (restart_mid && cyc == 10) begin
        reg_we = 1'b1; reg_addr = 3'd3; reg_wdata = 8'h01;
      end
    end
    chk(cyc == 32 * (int'(v.div) + 1), {tag, " R7 R3 cycles to irq"}, cyc, 32 * (int'(v.div) + 1));
    peek(3'd4, d);
    chk(d == 8'h03, {tag, " R7 busy+ready at irq"}, d, 8'h03);
    @(negedge clk);
    peek(3'd4, d);
    chk(d == 8'h01, {tag, " R7 busy cleared one clock later"}, d, 8'h01);
    sl_run = 0;
    chk(sck == v.cfg[1], {tag, " R3 sck idle level"}, sck, v.cfg[1]);
    chk(sl_gap_err == 0, {tag, " R3 sck half period"}, sl_gap_err, 0);
    chk(sl_edges == 16, {tag, " R3 sck edge count"}, sl_edges, 16);
    chk(sl_cap == v.tx, {tag, " R4 R5 mosi byte"}, sl_cap, v.tx);
    rd(3'd1, d);
    chk(d == v.exp_rx, {tag, " R4 R5 R6 received byte"}, d, v.exp_rx);
    chk(irq == 1'b0, {tag, " R8 irq after read"}, irq, 0);
    peek(3'd4, d);
    chk(d == 8'h00, {tag, " R8 status after read"}, d, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic       m0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    peek(3'd0, d); chk(d == 8'h00, "R1 cfg reset", d, 0);
    peek(3'd5, d); chk(d == 8'h00, "R1 div reset", d, 0);
    peek(3'd2, d); chk(d == 8'h00, "R1 txd reset", d, 0);
    peek(3'd1, d); chk(d == 8'h00, "R1 rxd reset", d, 0);
    peek(3'd4, d); chk(d == 8'h00, "R1 status reset", d, 0);
    chk({irq, sck, mosi} == 3'b000, "R1 pins reset", {irq, sck, mosi}, 0);

    // R9 readback
    wr(3'd0, 8'hF7); peek(3'd0, d); chk(d == 8'h17, "R9 cfg readback", d, 8'h17);
    wr(3'd2, 8'h6D); peek(3'd2, d); chk(d == 8'h6D, "R9 txd readback", d, 8'h6D);
    wr(3'd5, 8'hC4); peek(3'd5, d); chk(d == 8'hC4, "R9 div readback", d, 8'hC4);
    peek(3'd3, d); chk(d == 8'h00, "R9 cmd reads zero", d, 0);

    // R2 go while disabled
    wr(3'd5, 8'h00);
    wr(3'd0, 8'h12);
    wr(3'd3, 8'h01);
    repeat (3) @(negedge clk);
    peek(3'd4, d); chk(d == 8'h00, "R2 go ignored while disabled", d, 0);
    chk(sck == 1'b1, "R2 sck unchanged while disabled", sck, 1);

    // vector table
    foreach (VECS[i]) run_xfer(VECS[i], 1'b0, $sformatf("vec%0d", i));

    // R2 go while busy does not restart
    run_xfer('{8'h18, 8'd1, 8'hC6, 8'h5D, 8'h5D}, 1'b1, "busy-go R2");

    // R10 mosi holds, R3 sck follows idle level
    m0 = mosi;
    wr(3'd0, 8'h1A);
    repeat (4) @(negedge clk);
    chk(mosi == m0, "R10 mosi holds while idle", mosi, m0);
    chk(sck == 1'b1, "R3 sck follows idle level", sck, 1);
    wr(3'd0, 8'h18);
    @(negedge clk);
    chk(sck == 1'b0, "R3 sck back low", sck, 0);
    chk(mosi == m0, "R10 mosi still held", mosi, m0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule